// File: doc/BRIEF.md
# UART Interrupt Priority and Modem Status Unit

This block gathers the four interrupt sources of a serial port (receive line errors, receive data or receive timeout, transmit holding register empty, and modem line changes) and reduces them to one prioritized identification code that the host reads. A source takes part only while its enable bit is set. The receive sources and line errors are level conditions owned by the datapath. The transmit-empty source is an internal flag that is set on each new empty condition and cleared by an acknowledge. The modem source is set by a change on a modem line and cleared by reading the modem status byte.

The unit also holds the modem status byte. Its upper four bits show the current state of the four active-low modem inputs, inverted to active-high. Its lower four bits are change flags, which stay set until the host reads the byte. In loopback the modem status bits are taken from the unit's own modem control bits instead of from the input pins.

The interrupt request comes out as a level and a separate drive enable, so the pad can release the line when the output is disabled.

Top module: `uart_irq_modem_unit`

## Requirements
- R1: After a synchronous active-low reset, with all enables 0, `id_byte` reads 0x01 and `mstat_byte` reads 0x00 while every modem input is high.
- R2: Sources rank from highest to lowest as follows. Line error (enable bit 2) gives code 0x6. Receive (enable bit 0) comes next. Transmit empty (enable bit 1) gives 0x2. Modem change (enable bit 3) gives 0x0. When nothing is pending the code is 0x1. The code appears in `id_byte[3:0]`.
- R3: Data ready and timeout share the receive level. While `rx_ready` is 1 the code is 0x4. Code 0xC is reported only when `rx_timeout` is 1 and `rx_ready` is 0.
- R4: `id_byte[7:6]` both equal `fifo_en`, and `id_byte[5:4]` are 0.
- R5: A source whose enable bit is 0 never affects the code, even when its condition is present.
- R6: The transmit-empty flag behaves as follows.
  - It is set one clock after `thr_empty & irq_en[1]` rises. This covers enabling the source while the holding register is already empty.
  - It is cleared by `thr_wr`.
  - It is cleared by an `id_rd` in a cycle where 0x2 is the reported code.
  - An `id_rd` while another code is reported leaves it set.
- R7: The modem status byte holds four change flags.
  - Bit 0 (CTS), bit 1 (DSR) and bit 3 (CD) set on any change of their status bit.
  - Bit 2 (ring) sets only when the ring status goes from active to inactive.
- R8: A `mstat_rd` clears all change flags at the next clock. A change detected in the same cycle as the read still sets its flag.
- R9: Outside loopback, `mstat_byte[7:4]` equal the inverted `cd_n`, `ri_n`, `dsr_n`, `cts_n` (bit 7 down to bit 4), registered one clock.
- R10: In loopback, `mstat_byte[4]` shows `mctl[1]`, bit 5 shows `mctl[0]`, bit 6 shows `mctl[2]` and bit 7 shows `mctl[3]`. Change flags follow these values.
- R11: `irq_level` is 1 exactly when the code is not 0x1. `irq_drive` is `int_force | mctl[3]`.
- R12: When only the modem source is enabled, any set change flag produces code 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_en | input | 4 | Source enables: 0 receive, 1 transmit empty, 2 line error, 3 modem |
| line_err | input | 1 | Receive line error condition present |
| rx_ready | input | 1 | Receive data available / trigger reached |
| rx_timeout | input | 1 | Receive timeout condition |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Host write to transmit holding register |
| fifo_en | input | 1 | FIFOs enabled |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cd_n | input | 1 | Carrier detect, active low |
| mctl | input | 4 | Modem control: 0 DTR, 1 RTS, 2 OP1, 3 OP2 / interrupt drive |
| loopback | input | 1 | Loopback mode |
| int_force | input | 1 | Keep the interrupt output always driven |
| id_rd | input | 1 | Host read of identification byte (one cycle) |
| mstat_rd | input | 1 | Host read of modem status byte (one cycle) |
| id_byte | output | 8 | Identification byte |
| mstat_byte | output | 8 | Modem status byte |
| irq_level | output | 1 | Interrupt request level |
| irq_drive | output | 1 | Interrupt pad drive enable (0 = released) |

## Verification
The assertions check on every cycle that:
- line errors outrank all other sources;
- data ready outranks line-free receive timeout;
- a cleared enable mask yields the no-interrupt code;
- a leading ring edge never sets its flag;
- a read with no coincident change empties the change flags;
- a write or acknowledge clears the transmit-empty flag;
- loopback status tracks the modem control bits.

Only the bench's scenarios show the ordering effects, because they depend on a sequence of events:
- the transmit source being re-armed only by a new empty edge;
- an acknowledge that removes just the reported source, so a lower one then appears;
- a change that coincides with a status read being kept.

// File: rtl/uim_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the interrupt/modem status unit.
package uim_pkg;
    localparam int SRC_W  = 4;   // number of interrupt sources / enable bits
    localparam int MDM_W  = 4;   // number of modem status lines
    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;

    typedef logic [CODE_W-1:0] irq_code_t;

    localparam irq_code_t CODE_LINE = 4'h6;
    localparam irq_code_t CODE_RXRD = 4'h4;
    localparam irq_code_t CODE_RXTO = 4'hC;
    localparam irq_code_t CODE_TXE  = 4'h2;
    localparam irq_code_t CODE_MDM  = 4'h0;
    localparam irq_code_t CODE_NONE = 4'h1;

    // enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_TXE  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    // modem status line positions (status nibble / change nibble)
    localparam int ML_CTS = 0;
    localparam int ML_DSR = 1;
    localparam int ML_RI  = 2;
    localparam int ML_CD  = 3;
endpackage

// File: rtl/uim_modem_status.sv
`timescale 1ns/1ps
// Modem status register: registers the active-high line state and keeps
// sticky change flags. Lines whose bit is set in TRAIL_MASK flag only an
// active-to-inactive transition. Assumes inputs are already synchronous.
module uim_modem_status #(
    parameter int              N          = 4,
    parameter logic [N-1:0]    TRAIL_MASK = 4'b0100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_n,
    input  logic [N-1:0] loop_src,
    input  logic         loopback,
    input  logic         rd,
    output logic [N-1:0] stat_q,
    output logic [N-1:0] delta_q
);
    logic [N-1:0] stat_next;

    // Select the source of the status bits: pins or loopback control bits.
    always_comb stat_next = loopback ? loop_src : ~line_n;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic chg;
        if (TRAIL_MASK[i]) begin : g_trail
            // Trailing-edge detector for this line.
            always_comb chg = stat_q[i] & ~stat_next[i];

            p_trail_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_q[i] && stat_next[i] && !rd) |=> (delta_q[i] == $past(delta_q[i])));
        end else begin : g_any
            // Any-change detector for this line.
            always_comb chg = stat_q[i] ^ stat_next[i];
        end

        // Status and sticky change flag; a new change wins over a read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[i]  <= 1'b0;
                delta_q[i] <= 1'b0;
            end else begin
                stat_q[i]  <= stat_next[i];
                delta_q[i] <= (delta_q[i] & ~rd) | chg;
            end
        end
    end

    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (stat_next == stat_q)) |=> (delta_q == '0));
endmodule

// File: rtl/uim_tx_source.sv
`timescale 1ns/1ps
// Transmit-empty interrupt flag: armed by each rising edge of
// (holding register empty AND enabled), cleared by a holding register
// write or by an acknowledge (identification read reporting this source).
module uim_tx_source (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic enable,
    input  logic thr_wr,
    input  logic ack,
    output logic pend
);
    logic arm, arm_q, rise;

    // Detect a new enabled-empty condition.
    always_comb begin
        arm  = thr_empty & enable;
        rise = arm & ~arm_q;
    end

    // Edge history and pending flag; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            arm_q <= arm;
            pend  <= (pend & ~(thr_wr | ack)) | rise;
        end
    end

    p_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !rise) |=> !pend);
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rise) |=> !pend);
endmodule

// File: rtl/uim_priority.sv
`timescale 1ns/1ps
// Fixed-priority encoder from gated source conditions to the 4-bit
// identification code. Purely combinational.
module uim_priority
    import uim_pkg::*;
(
    input  logic [SRC_W-1:0] en,
    input  logic             line_err,
    input  logic             rx_ready,
    input  logic             rx_tmo,
    input  logic             tx_pend,
    input  logic             mdm_pend,
    output irq_code_t        code
);
    // Pick the highest enabled pending source.
    always_comb begin
        if (en[EN_LINE] && line_err)                  code = CODE_LINE;
        else if (en[EN_RX] && rx_ready)               code = CODE_RXRD;
        else if (en[EN_RX] && rx_tmo)                 code = CODE_RXTO;
        else if (en[EN_TXE] && tx_pend)               code = CODE_TXE;
        else if (en[EN_MDM] && mdm_pend)              code = CODE_MDM;
        else                                          code = CODE_NONE;
    end
endmodule

// File: rtl/uart_irq_modem_unit.sv
`timescale 1ns/1ps
// Top of the interrupt priority and modem status unit. Combines the
// source flags into the identification byte, holds the modem status
// byte with loopback remapping, and produces the interrupt level and
// pad drive enable. Host read strobes are single-cycle pulses.
module uart_irq_modem_unit
    import uim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  irq_en,
    input  logic              line_err,
    input  logic              rx_ready,
    input  logic              rx_timeout,
    input  logic              thr_empty,
    input  logic              thr_wr,
    input  logic              fifo_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              cd_n,
    input  logic [MDM_W-1:0]  mctl,
    input  logic              loopback,
    input  logic              int_force,
    input  logic              id_rd,
    input  logic              mstat_rd,
    output logic [BYTE_W-1:0] id_byte,
    output logic [BYTE_W-1:0] mstat_byte,
    output logic              irq_level,
    output logic              irq_drive
);
    localparam logic [MDM_W-1:0] RI_TRAIL = MDM_W'(1) << ML_RI;

    logic [MDM_W-1:0] pins_n, loop_src, stat_q, delta_q;
    logic             tx_pend, tx_ack;
    irq_code_t        code;

    // Arrange pins and loopback sources in status-bit order (CTS,DSR,RI,CD).
    always_comb begin
        pins_n   = {cd_n, ri_n, dsr_n, cts_n};
        loop_src = {mctl[3], mctl[2], mctl[0], mctl[1]};
    end

    uim_modem_status #(.N(MDM_W), .TRAIL_MASK(RI_TRAIL)) u_mstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (pins_n),
        .loop_src (loop_src),
        .loopback (loopback),
        .rd       (mstat_rd),
        .stat_q   (stat_q),
        .delta_q  (delta_q)
    );

    // Acknowledge of the transmit source: an id read while it is reported.
    always_comb tx_ack = id_rd && (code == CODE_TXE);

    uim_tx_source u_txsrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_empty (thr_empty),
        .enable    (irq_en[EN_TXE]),
        .thr_wr    (thr_wr),
        .ack       (tx_ack),
        .pend      (tx_pend)
    );

    uim_priority u_prio (
        .en       (irq_en),
        .line_err (line_err),
        .rx_ready (rx_ready),
        .rx_tmo   (rx_timeout),
        .tx_pend  (tx_pend),
        .mdm_pend (|delta_q),
        .code     (code)
    );

    // Assemble host-visible bytes and interrupt outputs.
    always_comb begin
        id_byte    = {fifo_en, fifo_en, 2'b00, code};
        mstat_byte = {stat_q, delta_q};
        irq_level  = (code != CODE_NONE);
        irq_drive  = int_force | mctl[3];
    end

    p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en[EN_LINE] && line_err) |-> (id_byte[3:0] == 4'h6));
    p_rx_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(irq_en[EN_LINE] && line_err) && irq_en[EN_RX] && rx_ready) |-> (id_byte[3:0] == 4'h4));
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> (id_byte[3:0] == 4'h1 && !irq_level));
    p_loop_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |=> (mstat_byte[7:4] == {$past(mctl[3]), $past(mctl[2]), $past(mctl[0]), $past(mctl[1])}));
endmodule

// File: tb/uart_irq_modem_unit_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases then seeded random stimulus,
// all compared against a bench-side behavioural model.
module uart_irq_modem_unit_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic       rst_n;
    logic [3:0] irq_en;
    logic       line_err, rx_ready, rx_timeout, thr_empty, thr_wr, fifo_en;
    logic       cts_n, dsr_n, ri_n, cd_n;
    logic [3:0] mctl;
    logic       loopback, int_force, id_rd, mstat_rd;
    logic [7:0] id_byte, mstat_byte;
    logic       irq_level, irq_drive;

    uart_irq_modem_unit dut_i (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .line_err(line_err),
        .rx_ready(rx_ready), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
        .thr_wr(thr_wr), .fifo_en(fifo_en), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .cd_n(cd_n), .mctl(mctl), .loopback(loopback),
        .int_force(int_force), .id_rd(id_rd), .mstat_rd(mstat_rd),
        .id_byte(id_byte), .mstat_byte(mstat_byte),
        .irq_level(irq_level), .irq_drive(irq_drive)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [3:0] m_stat, m_delta;
    logic       m_txp, m_arm;

    function automatic logic [3:0] f_code(input logic [3:0] en, input logic le,
                                          input logic rr, input logic rt,
                                          input logic txp, input logic [3:0] dl);
        if (en[2] && le)       return 4'h6;
        if (en[0] && rr)       return 4'h4;
        if (en[0] && rt)       return 4'hC;
        if (en[1] && txp)      return 4'h2;
        if (en[3] && (dl != 0)) return 4'h0;
        return 4'h1;
    endfunction

    function automatic logic [3:0] f_stat_next();
        return loopback ? {mctl[3], mctl[2], mctl[0], mctl[1]}
                        : ~{cd_n, ri_n, dsr_n, cts_n};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Inputs were set at a negedge: check outputs, advance model, next negedge.
    task automatic step(input string tag);
        logic [3:0] code, nst, chg;
        logic       arm;
        #1;
        code = f_code(irq_en, line_err, rx_ready, rx_timeout, m_txp, m_delta);
        chk(tag, "id_byte", id_byte, {fifo_en, fifo_en, 2'b00, code});
        chk(tag, "mstat_byte", mstat_byte, {m_stat, m_delta});
        chk(tag, "irq_level", {7'd0, irq_level}, {7'd0, code != 4'h1});
        chk(tag, "irq_drive", {7'd0, irq_drive}, {7'd0, int_force | mctl[3]});
        nst = f_stat_next();
        chg = m_stat ^ nst;
        chg[2] = m_stat[2] & ~nst[2];
        m_delta = (mstat_rd ? 4'h0 : m_delta) | chg;
        m_stat  = nst;
        arm   = thr_empty & irq_en[1];
        m_txp = (m_txp & ~(thr_wr | (id_rd && code == 4'h2))) | (arm & ~m_arm);
        m_arm = arm;
        @(negedge clk);
        id_rd = 0; mstat_rd = 0; thr_wr = 0;
    endtask

    initial begin
        #(200000 * 4);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5EED_0C1A);
        rst_n = 0; irq_en = 0; line_err = 0; rx_ready = 0; rx_timeout = 0;
        thr_empty = 1; thr_wr = 0; fifo_en = 0; cts_n = 1; dsr_n = 1; ri_n = 1; cd_n = 1;
        mctl = 0; loopback = 0; int_force = 0; id_rd = 0; mstat_rd = 0;
        m_stat = 0; m_delta = 0; m_txp = 0; m_arm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step("R1"); step("R1");
        // R6 enabling with empty register raises transmit-empty
        irq_en = 4'b0010; step("R6"); step("R6");
        id_rd = 1; step("R6"); step("R6");           // acknowledged -> 0x01
        thr_empty = 0; step("R6"); thr_empty = 1; step("R6"); step("R6");
        thr_wr = 1; step("R6"); step("R6");          // write clears
        // R6 read while a higher source is reported keeps tx flag
        thr_empty = 0; step("R6"); thr_empty = 1; step("R6");
        irq_en = 4'b0011; rx_ready = 1; id_rd = 1; step("R6");
        rx_ready = 0; step("R6");                    // tx now visible: 0x02
        id_rd = 1; step("R6"); step("R6");
        // R2/R3 priority
        irq_en = 4'hF; line_err = 1; rx_ready = 1; rx_timeout = 1; step("R2");
        line_err = 0; step("R3");
        rx_ready = 0; step("R3");
        rx_timeout = 0; step("R2");
        // R4 fifo bits
        fifo_en = 1; step("R4"); fifo_en = 0; step("R4");
        // R5 gating
        irq_en = 4'h0; line_err = 1; rx_ready = 1; step("R5");
        line_err = 0; rx_ready = 0; step("R5");
        // R7 change flags: CTS any change, RI trailing only
        cts_n = 0; step("R7"); step("R7");
        ri_n = 0; step("R7"); step("R7");            // leading ring edge: no flag
        ri_n = 1; step("R7"); step("R7");            // trailing edge: flag
        // R12 modem source
        irq_en = 4'h8; step("R12");
        // R8 read clears; coincident change kept
        mstat_rd = 1; step("R8"); step("R8");
        mstat_rd = 1; dsr_n = 0; step("R8"); step("R8");
        mstat_rd = 1; step("R8"); step("R12");
        // R9 status follows inverted pins
        cd_n = 0; cts_n = 1; step("R9"); step("R9");
        dsr_n = 1; cd_n = 1; step("R9"); step("R9");
        // R10 loopback mapping
        loopback = 1;
        for (int k = 0; k < 16; k++) begin
            mctl = 4'(k); step("R10"); step("R10");
        end
        loopback = 0; mctl = 0; step("R10");
        // R11 drive enable
        int_force = 1; step("R11"); int_force = 0; mctl = 4'h8; step("R11");
        mctl = 4'h0; step("R11");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            r = $urandom();
            irq_en     = r[3:0];
            line_err   = (r[6:4] == 0);
            rx_ready   = (r[8:7] == 0);
            rx_timeout = (r[10:9] == 0);
            if (r[13:11] == 0) thr_empty = ~thr_empty;
            thr_wr     = (r[15:14] == 0);
            id_rd      = (r[17:16] == 0);
            mstat_rd   = (r[19:18] == 0);
            if (r[22:20] == 0) cts_n = ~cts_n;
            if (r[25:23] == 0) dsr_n = ~dsr_n;
            if (r[28:26] == 0) ri_n  = ~ri_n;
            if (r[31:29] == 0) cd_n  = ~cd_n;
            r = $urandom();
            if (r[3:0] == 0) mctl = r[7:4];
            if (r[10:8] == 0) loopback = ~loopback;
            fifo_en   = r[11];
            int_force = (r[13:12] == 0);
            step("R2");
        end
        finish_run();
    end
endmodule